// File: doc/BRIEF.md
# Address Breakpoint Comparator

This block compares one data access against four programmable address breakpoints. Each breakpoint has an address register and a four-bit slice of a shared 32-bit control word. That slice holds an enable pair, an access-type code and a length code. The access is given as its start address, its size in bytes (1 to 8) and two access-type codes. A breakpoint whose type equals either code may match.

The breakpoint region is the register value aligned down to the region length. The region runs from that aligned start up to the start plus the alignment mask. The access runs from its start to start + size − 1. A breakpoint hits when it is enabled, its type matches, and the two byte ranges overlap. The block reports one bit for each breakpoint that hit, meant to be ORed into a status register, and a single flag that is set when any breakpoint hit. The parameter `REG_OUT` selects one flop stage on the outputs (the default) or a purely combinational path.

Top module: `addr_bp_comparator`

## Requirements
- R1: Breakpoint i is enabled when ctrl bit 2i or ctrl bit 2i+1 is 1. With both bits 0 it never reports a hit, even if its address and type match.
- R2: Breakpoint i's type code is ctrl[17+4i:16+4i]. A hit requires this code to equal `acc_kind_a` or `acc_kind_b`. Either code may be the one that matches.
- R3: Breakpoint i's length code is ctrl[19+4i:18+4i]. Code 00 means 1 byte (mask 0x0), 01 means 2 bytes (mask 0x1), 11 means 4 bytes (mask 0x3) and 10 means 8 bytes (mask 0x7). The region start is the register value with the mask bits cleared, and the region end is that start plus the mask.
- R4: The access ends at `acc_addr + acc_size − 1`, taken modulo 2^AW, with no flag on wrap. All comparisons are unsigned.
- R5: The access overlaps a region when access start ≤ region end and access end ≥ region start. This includes an access that straddles either edge of the region.
- R6: `hit_mask` bit i (weight 1, 2, 4, 8 for i = 0..3) is 1 exactly when breakpoint i is enabled, its type matches and the ranges overlap. Otherwise the bit is 0.
- R7: `hit_any` is 1 exactly when `hit_mask` is nonzero.
- R8: With REG_OUT=1 the outputs reflect the inputs present at the previous rising clock edge. A synchronous active-high `rst` forces both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| bp_addr | input | 4*AW | Breakpoint address registers; breakpoint i in bits [AW*i+AW-1:AW*i] |
| ctrl | input | 32 | Control word: enable pairs, type and length codes |
| acc_addr | input | AW | Start address of the access |
| acc_size | input | 4 | Access size in bytes, 1 to 8 |
| acc_kind_a | input | 2 | First access-type code to match |
| acc_kind_b | input | 2 | Second access-type code to match |
| hit_any | output | 1 | Some breakpoint hit |
| hit_mask | output | 4 | Per-breakpoint hit bits |

## Verification
The hardest situations to reach are the partial overlaps at region edges: accesses that start before a region and end inside it, or start in its last byte. The 8-byte length code makes these harder still, because it aligns down by three bits. Random addresses over a full 32-bit space would almost never land on them. So the random stimulus draws every breakpoint address and access address from one 48-byte window, which makes near misses and straddles common. Directed vectors then place accesses exactly one byte inside and one byte outside each edge. Separate directed vectors cover a disabled breakpoint that would otherwise match, and an access whose end wraps past the top of the address space.

// File: rtl/bp_cmp_pkg.sv
package bp_cmp_pkg;

    localparam int NUM_BP  = 4;
    localparam int CTRL_W  = 32;
    localparam int KIND_W  = 2;
    localparam int SIZE_W  = 4;
    localparam int MASK_W  = 3;
    localparam int KIND_LO = 16;   // type field of slot 0
    localparam int SLOT_W  = 4;    // type + length bits per slot

    typedef enum logic [1:0] {
        LEN_1B = 2'b00,
        LEN_2B = 2'b01,
        LEN_8B = 2'b10,
        LEN_4B = 2'b11
    } bp_len_e;

    typedef struct packed {
        logic              enabled;
        logic [KIND_W-1:0] kind;
        bp_len_e           len;
    } bp_cfg_t;

    function automatic logic [MASK_W-1:0] len_to_mask(bp_len_e l);
        case (l)
            LEN_1B:  return 3'b000;
            LEN_2B:  return 3'b001;
            LEN_4B:  return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/bp_ctrl_unpack.sv
module bp_ctrl_unpack
    import bp_cmp_pkg::*;
(
    input  logic [CTRL_W-1:0]          ctrl,
    output bp_cfg_t [NUM_BP-1:0]       cfg
);
    // Bits between the enable pairs and the first slot field are not used.
    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^ctrl[KIND_LO-1:2*NUM_BP];

    for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
        localparam int FLD = KIND_LO + SLOT_W * i;
        always_comb begin
            cfg[i].enabled = |ctrl[2*i +: 2];
            cfg[i].kind    = ctrl[FLD +: KIND_W];
            cfg[i].len     = bp_len_e'(ctrl[FLD + KIND_W +: 2]);
        end
    end
endmodule

// File: rtl/bp_region_match.sv
module bp_region_match
    import bp_cmp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]     bp_addr,
    input  bp_cfg_t           cfg,
    input  logic [AW-1:0]     acc_lo,
    input  logic [AW-1:0]     acc_hi,
    input  logic [KIND_W-1:0] kind_a,
    input  logic [KIND_W-1:0] kind_b,
    output logic              hit
);
    localparam int PAD = AW - MASK_W;

    logic [AW-1:0] span;
    logic [AW-1:0] reg_lo;
    logic [AW-1:0] reg_hi;
    logic          kind_ok;
    logic          overlap;

    always_comb begin
        span    = {{PAD{1'b0}}, len_to_mask(cfg.len)};
        reg_lo  = bp_addr & ~span;
        reg_hi  = reg_lo | span;   // low bits are clear, so OR equals add
        kind_ok = (cfg.kind == kind_a) || (cfg.kind == kind_b);
        overlap = (acc_lo <= reg_hi) && (acc_hi >= reg_lo);
        hit     = cfg.enabled && kind_ok && overlap;
    end
endmodule

// File: rtl/bp_result_stage.sv
module bp_result_stage
    import bp_cmp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_BP-1:0] hit_vec,
    output logic [NUM_BP-1:0] hit_mask,
    output logic              hit_any
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                hit_mask <= '0;
                hit_any  <= 1'b0;
            end else begin
                hit_mask <= hit_vec;
                hit_any  <= |hit_vec;
            end
        end
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst;
        assign hit_mask = hit_vec;
        assign hit_any  = |hit_vec;
    end
endmodule

// File: rtl/addr_bp_comparator.sv
module addr_bp_comparator
    import bp_cmp_pkg::*;
#(
    parameter int AW      = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BP*AW-1:0] bp_addr,
    input  logic [CTRL_W-1:0]    ctrl,
    input  logic [AW-1:0]        acc_addr,
    input  logic [SIZE_W-1:0]    acc_size,
    input  logic [KIND_W-1:0]    acc_kind_a,
    input  logic [KIND_W-1:0]    acc_kind_b,
    output logic                 hit_any,
    output logic [NUM_BP-1:0]    hit_mask
);
    bp_cfg_t [NUM_BP-1:0] cfg;
    logic    [NUM_BP-1:0] hit_vec;
    logic    [AW-1:0]     acc_hi;

    // Access end wraps modulo 2^AW by design.
    assign acc_hi = acc_addr + {{(AW-SIZE_W){1'b0}}, acc_size} - {{(AW-1){1'b0}}, 1'b1};

    bp_ctrl_unpack u_unpack (
        .ctrl (ctrl),
        .cfg  (cfg)
    );

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        bp_region_match #(.AW(AW)) u_match (
            .bp_addr (bp_addr[AW*i +: AW]),
            .cfg     (cfg[i]),
            .acc_lo  (acc_addr),
            .acc_hi  (acc_hi),
            .kind_a  (acc_kind_a),
            .kind_b  (acc_kind_b),
            .hit     (hit_vec[i])
        );
    end

    bp_result_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk      (clk),
        .rst      (rst),
        .hit_vec  (hit_vec),
        .hit_mask (hit_mask),
        .hit_any  (hit_any)
    );
endmodule

// File: rtl/bp_cmp_checker.sv
module bp_cmp_checker
    import bp_cmp_pkg::*;
#(
    parameter int AW      = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CTRL_W-1:0]    ctrl,
    input logic [KIND_W-1:0]    acc_kind_a,
    input logic [KIND_W-1:0]    acc_kind_b,
    input logic                 hit_any,
    input logic [NUM_BP-1:0]    hit_mask
);
    assert_any_tracks_mask_R7: assert property (@(posedge clk) disable iff (rst)
        hit_any == (hit_mask != '0));

    if (REG_OUT) begin : g_seq
        assert_reset_clears_R8: assert property (@(posedge clk)
            rst |=> (hit_mask == '0 && !hit_any));

        for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
            assert_hit_needs_enable_R1: assert property (@(posedge clk) disable iff (rst)
                hit_mask[i] |-> ($past(ctrl[2*i +: 2]) != 2'b00));
            assert_hit_needs_kind_R2: assert property (@(posedge clk) disable iff (rst)
                hit_mask[i] |->
                    (($past(ctrl[KIND_LO + SLOT_W*i +: KIND_W]) == $past(acc_kind_a)) ||
                     ($past(ctrl[KIND_LO + SLOT_W*i +: KIND_W]) == $past(acc_kind_b))));
        end
    end else begin : g_comb
        for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
            assert_hit_needs_enable_R1: assert property (@(posedge clk) disable iff (rst)
                hit_mask[i] |-> (ctrl[2*i +: 2] != 2'b00));
            assert_hit_needs_kind_R2: assert property (@(posedge clk) disable iff (rst)
                hit_mask[i] |->
                    ((ctrl[KIND_LO + SLOT_W*i +: KIND_W] == acc_kind_a) ||
                     (ctrl[KIND_LO + SLOT_W*i +: KIND_W] == acc_kind_b)));
        end
    end
endmodule

bind addr_bp_comparator bp_cmp_checker #(.AW(AW), .REG_OUT(REG_OUT)) u_bp_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .acc_kind_a (acc_kind_a),
    .acc_kind_b (acc_kind_b),
    .hit_any    (hit_any),
    .hit_mask   (hit_mask)
);

// File: tb/addr_bp_comparator_bench.sv
module addr_bp_comparator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [4*AW-1:0] bp_addr = '0;
    logic [31:0]     ctrl = '0;
    logic [AW-1:0]   acc_addr = '0;
    logic [3:0]      acc_size = 4'd1;
    logic [1:0]      acc_kind_a = '0;
    logic [1:0]      acc_kind_b = '0;
    logic            hit_any;
    logic [3:0]      hit_mask;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_bp_comparator #(.AW(AW), .REG_OUT(1'b1)) u_addr_bp_comparator (
        .clk(clk), .rst(rst), .bp_addr(bp_addr), .ctrl(ctrl),
        .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_kind_a(acc_kind_a), .acc_kind_b(acc_kind_b),
        .hit_any(hit_any), .hit_mask(hit_mask)
    );

    // Slot field: enable pair en, type k, length code l.
    function automatic logic [31:0] slot(int i, logic [1:0] en, logic [1:0] k, logic [1:0] l);
        logic [31:0] c = '0;
        c[2*i +: 2]      = en;
        c[16+4*i +: 2]   = k;
        c[18+4*i +: 2]   = l;
        return c;
    endfunction

    function automatic logic [3:0] model(logic [4*AW-1:0] bpa, logic [31:0] c,
                                         logic [AW-1:0] a, logic [3:0] sz,
                                         logic [1:0] ka, logic [1:0] kb);
        logic [3:0] m = '0;
        for (int i = 0; i < 4; i++) begin
            logic [1:0]    l  = c[18+4*i +: 2];
            logic [1:0]    k  = c[16+4*i +: 2];
            logic [AW-1:0] mk = (l == 2'b00) ? 0 : (l == 2'b01) ? 1 : (l == 2'b11) ? 3 : 7;
            logic [AW-1:0] rs = bpa[AW*i +: AW] & ~mk;
            logic [AW-1:0] re = rs + mk;
            logic [AW-1:0] ae = a + AW'(sz) - 1;
            if ((c[2*i +: 2] != 0) && (k == ka || k == kb) && a <= re && ae >= rs)
                m[i] = 1'b1;
        end
        return m;
    endfunction

    task automatic check(string tag, logic [3:0] exp_m);
        n_vec++;
        if (hit_mask !== exp_m || hit_any !== (exp_m != 0)) begin
            n_bad++;
            $display("FAIL %s: mask=%h any=%b expected mask=%h any=%b",
                     tag, hit_mask, hit_any, exp_m, exp_m != 0);
        end
    endtask

    task automatic apply(string tag, logic [4*AW-1:0] bpa, logic [31:0] c,
                         logic [AW-1:0] a, logic [3:0] sz,
                         logic [1:0] ka, logic [1:0] kb, logic [3:0] exp_m);
        @(negedge clk);
        bp_addr = bpa; ctrl = c; acc_addr = a; acc_size = sz;
        acc_kind_a = ka; acc_kind_b = kb;
        @(negedge clk);   // one output register between
        check(tag, exp_m);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [4*AW-1:0] bpa;
        void'($urandom(32'h5eed_1234));
        // R8: reset holds outputs low even with a matching setup
        bpa = '0; bpa[0 +: AW] = 32'h40;
        ctrl = slot(0, 2'b01, 2'b00, 2'b00); bp_addr = bpa; acc_addr = 32'h40;
        repeat (3) @(negedge clk);
        check("R8 reset", 4'h0);
        @(negedge clk); rst = 1'b0;

        // R5 straddle into a 4-byte region 0x1004..0x1007 from below
        bpa = '0; bpa[0 +: AW] = 32'h1006;
        apply("R5 straddle low edge", bpa, slot(0, 2'b01, 2'b01, 2'b11), 32'h1002, 4'd4, 2'b01, 2'b00, 4'h1);
        apply("R5 one byte below", bpa, slot(0, 2'b01, 2'b01, 2'b11), 32'h1000, 4'd4, 2'b01, 2'b00, 4'h0);
        apply("R5 straddle high edge", bpa, slot(0, 2'b10, 2'b01, 2'b11), 32'h1007, 4'd8, 2'b01, 2'b01, 4'h1);
        apply("R5 one byte above", bpa, slot(0, 2'b10, 2'b01, 2'b11), 32'h1008, 4'd8, 2'b01, 2'b01, 4'h0);

        // R3 8-byte code 10: region 0x2000..0x2007
        bpa = '0; bpa[AW +: AW] = 32'h2005;
        apply("R3 len8 last byte", bpa, slot(1, 2'b11, 2'b11, 2'b10), 32'h2007, 4'd1, 2'b11, 2'b00, 4'h2);
        apply("R3 len8 first byte", bpa, slot(1, 2'b11, 2'b11, 2'b10), 32'h1FFF, 4'd2, 2'b11, 2'b00, 4'h2);
        apply("R3 len8 past end", bpa, slot(1, 2'b11, 2'b11, 2'b10), 32'h2008, 4'd1, 2'b11, 2'b00, 4'h0);
        apply("R3 len2 aligned", bpa, slot(1, 2'b01, 2'b11, 2'b01), 32'h2003, 4'd1, 2'b11, 2'b00, 4'h0);
        apply("R3 len1 exact", bpa, slot(1, 2'b01, 2'b11, 2'b00), 32'h2005, 4'd1, 2'b11, 2'b00, 4'h2);

        // R1 / R6 disabled but otherwise matching
        bpa = '0; bpa[2*AW +: AW] = 32'h3000;
        apply("R1 disabled match", bpa, slot(2, 2'b00, 2'b00, 2'b11), 32'h3000, 4'd4, 2'b00, 2'b00, 4'h0);
        apply("R6 enabled match", bpa, slot(2, 2'b01, 2'b00, 2'b11), 32'h3000, 4'd4, 2'b00, 2'b00, 4'h4);

        // R2 type mismatch, then match via second code
        bpa = '0; bpa[3*AW +: AW] = 32'h4000;
        apply("R2 type mismatch", bpa, slot(3, 2'b01, 2'b11, 2'b00), 32'h4000, 4'd1, 2'b00, 2'b01, 4'h0);
        apply("R2 match code b", bpa, slot(3, 2'b01, 2'b11, 2'b00), 32'h4000, 4'd1, 2'b00, 2'b11, 4'h8);

        // R4 access end wraps past the top: start > region end, no hit
        bpa = '0;
        apply("R4 wrap", bpa, slot(0, 2'b01, 2'b00, 2'b00), 32'hFFFF_FFFE, 4'd4, 2'b00, 2'b00, 4'h0);

        // R7 all four hit together
        bpa = {4{32'h5000}};
        apply("R7 all hit", bpa,
              slot(0,2'b01,2'b00,2'b00) | slot(1,2'b10,2'b00,2'b01) |
              slot(2,2'b11,2'b00,2'b11) | slot(3,2'b01,2'b00,2'b10),
              32'h5000, 4'd1, 2'b00, 2'b10, 4'hF);

        // R6 random within a 48-byte window
        for (int n = 0; n < 400; n++) begin
            logic [31:0] c = $urandom;
            logic [AW-1:0] a = 32'h8000 + ($urandom % 48);
            logic [3:0] sz = 4'(1 + ($urandom % 8));
            logic [1:0] ka = 2'($urandom);
            logic [1:0] kb = 2'($urandom);
            for (int i = 0; i < 4; i++) bpa[AW*i +: AW] = 32'h8000 + ($urandom % 48);
            apply("R6 random", bpa, c, a, sz, ka, kb, model(bpa, c, a, sz, ka, kb));
        end

        // R8 reset again clears a hit on the next edge
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R8 reset mid-run", 4'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule